// File: doc/BRIEF.md
# Serial Line Auto-Baud Measurement Unit

This block calibrates a UART baud rate generator by timing a known character on the receive line. Software arms it with an enable write. The block then clears its measurement counter and waits for the falling edge of a start bit. The character it expects is 0x55, whose bits alternate, so the line carries a rising edge at the end of every low bit. The counter runs from the first rising edge after the start bit to the fifth one. That span is eight bit times and covers four low and four high bits, so any asymmetry between low and high levels averages out.

The counter advances at one eighth of the rate the baud generator would use in the selected clock mode, so the final count equals the generator divisor directly. When the fifth rising edge arrives, the enable drops by itself and a sticky completion flag rises. Software clears that flag with a read strobe. A sticky wrap flag records any counter rollover. Software can also write the wrap flag. While a measurement is armed, the block blocks transmit-register writes and holds the receiver idle.

Top module: `abd_autobaud`

## Requirements
- R1: An enable write of 1 takes effect only when `async_mode_i` is 1 and `wake_en_i` is 0. Otherwise `en_o` stays 0.
- R2: A successful arm sets `en_o` and clears `cnt_o` to 0 on the same clock edge. The block then waits for a falling edge on the synchronized RX line.
- R3: After the start bit, counting begins on the first rising edge of RX and ends on the fifth. For a 0x55 frame with bit time T clocks, the result is 8*T divided by the prescale.
- R4: The prescale is selected by {`mode16_i`,`mode_hs_i`}. The value 00 gives 512, 01 and 10 give 128, and 11 gives 32 system clocks per count.
- R5: On the fifth rising edge, `en_o` clears without any software write, `done_o` sets, and `cnt_o` then holds its value.
- R6: `done_o` stays set until `rd_strobe_i` is pulsed, and it clears on the following edge.
- R7: A counter wrap from all ones to zero sets `ovf_o`. The flag is sticky, and the measurement goes on with the count taken modulo 2^CNT_W.
- R8: A pulse on `ovf_wr_i` loads `ovf_wdata_i` into `ovf_o`. Software can therefore both clear and set the flag.
- R9: While `en_o` is 1, `tx_wr_ok_o` is 0 and `rx_hold_o` is 1. While `en_o` is 0, `tx_wr_ok_o` follows `tx_wr_i` and `rx_hold_o` is 0.
- R10: When `mode16_i` is 0, `div_o` holds only the low 8 bits of the count, with the upper bits zero. `cnt_o` still shows the full count, so software can confirm that no carry reached the upper byte. When `mode16_i` is 1, `div_o` equals `cnt_o`.
- R11: An enable write of 0 during a measurement aborts it. `en_o` clears, `done_o` stays 0, and `cnt_o` freezes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode_i | input | 1 | Serial port is in asynchronous mode |
| wake_en_i | input | 1 | Wake-up-on-receive is enabled (blocks arming) |
| mode16_i | input | 1 | 16-bit generator mode |
| mode_hs_i | input | 1 | High-speed generator mode |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| ovf_wr_i | input | 1 | Write strobe for the wrap flag |
| ovf_wdata_i | input | 1 | Value written to the wrap flag |
| rd_strobe_i | input | 1 | Receive-data read, clears the completion flag |
| tx_wr_i | input | 1 | Transmit-register write request |
| rx_i | input | 1 | Asynchronous serial receive line |
| en_o | output | 1 | Enable bit, high while a measurement is armed or running |
| done_o | output | 1 | Sticky completion flag |
| ovf_o | output | 1 | Sticky counter-wrap flag |
| cnt_o | output | CNT_W | Full measurement counter |
| div_o | output | CNT_W | Divisor for the selected width mode |
| tx_wr_ok_o | output | 1 | Transmit write allowed through |
| rx_hold_o | output | 1 | Holds the receive state machine idle |

## Verification
The bench measures frames in all four prescale codes. It uses bit times chosen so that the expected count is exact. A one-cycle slip at either end of the window, or an off-by-one in the prescaler, therefore shows as a wrong count. In 8-bit mode it uses a count above 255 to catch a divisor that leaks the upper byte or a counter that truncates. On a narrow-counter instance it pushes the count past its wrap. A design that stopped counting or cleared the count there would miss the expected modulo value or leave the wrap flag low. The bench also arms while the mode is wrong, and it aborts a measurement in mid-frame. A design that honoured the first or raised completion on the second would be caught.

// File: rtl/abd_pkg.sv
package abd_pkg;
   typedef enum logic [1:0] {
      ABD_OFF        = 2'd0,
      ABD_WAIT_START = 2'd1,
      ABD_WAIT_RISE  = 2'd2,
      ABD_COUNT      = 2'd3
   } abd_state_t;

   // rising edges of a 0x55 frame from the end of start bit to the stop bit
   localparam int ABD_RISES = 5;
   localparam int ABD_EDGE_W = $clog2(ABD_RISES + 1);
   localparam int ABD_LOW_BYTE = 8;
endpackage

// File: rtl/abd_rx_sync.sv
module abd_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("abd_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         prev <= 1'b1;
      end else begin
         sh   <= {sh[STAGES-2:0], rx_i};
         prev <= sh[STAGES-1];
      end
   end

   assign rise_o = sh[STAGES-1] & ~prev;
   assign fall_o = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/abd_prescale.sv
module abd_prescale #(
   parameter int DIV_SLOW = 512,
   parameter int DIV_MID  = 128,
   parameter int DIV_FAST = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic mode16_i,
   input  logic mode_hs_i,
   output logic tick_o
);
   localparam int PW = $clog2(DIV_SLOW);
   localparam logic [PW-1:0] LIM_S = PW'(DIV_SLOW - 1);
   localparam logic [PW-1:0] LIM_M = PW'(DIV_MID - 1);
   localparam logic [PW-1:0] LIM_F = PW'(DIV_FAST - 1);

   if (DIV_FAST < 2 || DIV_MID < DIV_FAST || DIV_SLOW < DIV_MID) begin : g_bad_div
      $error("abd_prescale: need 2 <= DIV_FAST <= DIV_MID <= DIV_SLOW");
   end

   logic [PW-1:0] pre;
   logic [PW-1:0] lim;

   always_comb begin
      case ({mode16_i, mode_hs_i})
         2'b00:   lim = LIM_S;
         2'b11:   lim = LIM_F;
         default: lim = LIM_M;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
      end else if (clr_i) begin
         pre <= '0;
      end else if (run_i) begin
         if (pre >= lim) pre <= '0;
         else            pre <= pre + 1'b1;
      end
   end

   assign tick_o = run_i & (pre >= lim);
endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (inc_i)  cnt_o <= cnt_o + 1'b1;
   end

   assign wrap_o = inc_i & (&cnt_o);
endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
   import abd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic allowed_i,
   input  logic en_wr_i,
   input  logic en_wdata_i,
   input  logic rise_i,
   input  logic fall_i,
   output logic en_o,
   output logic arm_o,
   output logic pre_clr_o,
   output logic run_o,
   output logic done_set_o
);
   abd_state_t            st, st_nx;
   logic [ABD_EDGE_W-1:0] edges, edges_nx;
   logic                  abort;

   assign abort = en_wr_i & ~en_wdata_i & (st != ABD_OFF);
   assign arm_o = en_wr_i & en_wdata_i & allowed_i & (st == ABD_OFF);

   always_comb begin
      st_nx      = st;
      edges_nx   = edges;
      pre_clr_o  = 1'b0;
      done_set_o = 1'b0;
      if (abort) begin
         st_nx = ABD_OFF;
      end else begin
         case (st)
            ABD_OFF: begin
               if (arm_o) st_nx = ABD_WAIT_START;
            end
            ABD_WAIT_START: begin
               if (fall_i) st_nx = ABD_WAIT_RISE;
            end
            ABD_WAIT_RISE: begin
               if (rise_i) begin
                  st_nx     = ABD_COUNT;
                  pre_clr_o = 1'b1;
                  edges_nx  = ABD_EDGE_W'(1);
               end
            end
            ABD_COUNT: begin
               if (rise_i) begin
                  if (edges == ABD_EDGE_W'(ABD_RISES - 1)) begin
                     st_nx      = ABD_OFF;
                     done_set_o = 1'b1;
                  end else begin
                     edges_nx = edges + 1'b1;
                  end
               end
            end
            default: st_nx = ABD_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ABD_OFF;
         edges <= '0;
      end else begin
         st    <= st_nx;
         edges <= edges_nx;
      end
   end

   assign en_o  = (st != ABD_OFF);
   assign run_o = (st == ABD_COUNT);
endmodule

// File: rtl/abd_autobaud.sv
module abd_autobaud
   import abd_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_SLOW    = 512,
   parameter int DIV_MID     = 128,
   parameter int DIV_FAST    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             async_mode_i,
   input  logic             wake_en_i,
   input  logic             mode16_i,
   input  logic             mode_hs_i,
   input  logic             en_wr_i,
   input  logic             en_wdata_i,
   input  logic             ovf_wr_i,
   input  logic             ovf_wdata_i,
   input  logic             rd_strobe_i,
   input  logic             tx_wr_i,
   input  logic             rx_i,
   output logic             en_o,
   output logic             done_o,
   output logic             ovf_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] div_o,
   output logic             tx_wr_ok_o,
   output logic             rx_hold_o
);
   if (CNT_W < ABD_LOW_BYTE) begin : g_bad_width
      $error("abd_autobaud: CNT_W must be at least 8");
   end

   logic rise, fall;
   logic arm, pre_clr, run, tick, done_set, wrap;

   abd_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .rise_o(rise), .fall_o(fall)
   );

   abd_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .allowed_i(async_mode_i & ~wake_en_i),
      .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
      .rise_i(rise), .fall_i(fall),
      .en_o(en_o), .arm_o(arm), .pre_clr_o(pre_clr),
      .run_o(run), .done_set_o(done_set)
   );

   abd_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_i(pre_clr), .run_i(run),
      .mode16_i(mode16_i), .mode_hs_i(mode_hs_i), .tick_o(tick)
   );

   abd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(arm), .inc_i(tick),
      .cnt_o(cnt_o), .wrap_o(wrap)
   );

   // sticky flags: hardware set wins over a same-cycle software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         if (done_set)         done_o <= 1'b1;
         else if (rd_strobe_i) done_o <= 1'b0;
         if (wrap)             ovf_o  <= 1'b1;
         else if (ovf_wr_i)    ovf_o  <= ovf_wdata_i;
      end
   end

   if (CNT_W > ABD_LOW_BYTE) begin : g_div_split
      assign div_o = mode16_i ? cnt_o
                              : {{(CNT_W-ABD_LOW_BYTE){1'b0}}, cnt_o[ABD_LOW_BYTE-1:0]};
   end else begin : g_div_flat
      assign div_o = cnt_o;
   end

   assign tx_wr_ok_o = tx_wr_i & ~en_o;
   assign rx_hold_o  = en_o;
endmodule

// File: rtl/abd_autobaud_chk.sv
module abd_autobaud_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             async_mode_i,
   input logic             wake_en_i,
   input logic             en_wr_i,
   input logic             ovf_wr_i,
   input logic             rd_strobe_i,
   input logic             en_o,
   input logic             done_o,
   input logic             ovf_o,
   input logic [CNT_W-1:0] cnt_o
);
   AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && (wake_en_i || !async_mode_i)) |=> !en_o); // R1

   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> (cnt_o == '0)); // R2

   AST_DONE_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_o) && !$past(en_wr_i)) |-> done_o); // R5

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !en_wr_i) |=> $stable(cnt_o)); // R5

   AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && rd_strobe_i && !en_o) |=> !done_o); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_wr_i) |=> ovf_o); // R7
endmodule

bind abd_autobaud abd_autobaud_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_abd_autobaud.sv
module sim_abd_autobaud;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic async_mode = 1'b1, wake_en = 1'b0, mode16 = 1'b1, mode_hs = 1'b1;
   logic en_wr = 1'b0, en_wdata = 1'b0, ovf_wr = 1'b0, ovf_wdata = 1'b0;
   logic rd_strobe = 1'b0, tx_wr = 1'b0, rx = 1'b1;
   logic        en0, done0, ovf0, txok0, hold0;
   logic [15:0] cnt0, div0;
   logic        en1, done1, ovf1, txok1, hold1;
   logic [9:0]  cnt1, div1;
   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   abd_autobaud u0 (
      .clk(clk), .rst_n(rst_n), .async_mode_i(async_mode), .wake_en_i(wake_en),
      .mode16_i(mode16), .mode_hs_i(mode_hs), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
      .ovf_wr_i(ovf_wr), .ovf_wdata_i(ovf_wdata), .rd_strobe_i(rd_strobe),
      .tx_wr_i(tx_wr), .rx_i(rx), .en_o(en0), .done_o(done0), .ovf_o(ovf0),
      .cnt_o(cnt0), .div_o(div0), .tx_wr_ok_o(txok0), .rx_hold_o(hold0)
   );

   // narrow counter so a wrap is reachable in a short run
   abd_autobaud #(.CNT_W(10)) u1 (
      .clk(clk), .rst_n(rst_n), .async_mode_i(async_mode), .wake_en_i(wake_en),
      .mode16_i(mode16), .mode_hs_i(mode_hs), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
      .ovf_wr_i(ovf_wr), .ovf_wdata_i(ovf_wdata), .rd_strobe_i(rd_strobe),
      .tx_wr_i(tx_wr), .rx_i(rx), .en_o(en1), .done_o(done1), .ovf_o(ovf1),
      .cnt_o(cnt1), .div_o(div1), .tx_wr_ok_o(txok1), .rx_hold_o(hold1)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_en(input logic v);
      @(negedge clk); en_wr = 1'b1; en_wdata = v;
      @(negedge clk); en_wr = 1'b0; en_wdata = 1'b0;
   endtask

   task automatic read_data();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   // start bit, 0x55 LSB first, stop bit; optional mid-frame checks, optional cut-off
   task automatic send_frame(input int t, input bit mid, input int nbits);
      logic [7:0] d = 8'h55;
      @(negedge clk); rx = 1'b0;
      idle(t - 1);
      for (int i = 0; i < nbits; i++) begin
         rx = d[i];
         idle(t);
         if (mid && i == 3) begin
            tx_wr = 1'b1;
            #1;
            check("R9", "en mid-frame", int'(en0), 1);
            check("R9", "tx write blocked", int'(txok0), 0);
            check("R9", "rx held idle", int'(hold0), 1);
            check("R5", "done not early", int'(done0), 0);
            tx_wr = 1'b0;
         end
      end
      rx = 1'b1;
      if (nbits == 8) idle(t);
      idle(20);
   endtask

   task automatic t_reset();
      check("R5", "reset en", int'(en0), 0);
      check("R6", "reset done", int'(done0), 0);
      check("R7", "reset ovf", int'(ovf0), 0);
      check("R2", "reset cnt", int'(cnt0), 0);
      tx_wr = 1'b1; #1;
      check("R9", "tx passes when idle", int'(txok0), 1);
      check("R9", "rx not held", int'(hold0), 0);
      tx_wr = 1'b0;
   endtask

   task automatic t_gating();
      wake_en = 1'b1;
      write_en(1'b1);
      check("R1", "arm with wake enabled", int'(en0), 0);
      wake_en = 1'b0; async_mode = 1'b0;
      write_en(1'b1);
      check("R1", "arm in sync mode", int'(en0), 0);
      async_mode = 1'b1;
   endtask

   task automatic measure(input logic m16, input logic hs, input int t,
                          input int exp_cnt, input int exp_div, input string req);
      mode16 = m16; mode_hs = hs;
      write_en(1'b1);
      check("R2", "armed", int'(en0), 1);
      check("R2", "count cleared on arm", int'(cnt0), 0);
      send_frame(t, 1'b1, 8);
      check(req, "count", int'(cnt0), exp_cnt);
      check(req, "divisor", int'(div0), exp_div);
      check("R5", "enable auto-clear", int'(en0), 0);
      check("R5", "done raised", int'(done0), 1);
      idle(30);
      check("R5", "count holds", int'(cnt0), exp_cnt);
      check("R6", "done sticky", int'(done0), 1);
      read_data();
      check("R6", "done cleared by read", int'(done0), 0);
   endtask

   task automatic t_abort();
      int held;
      mode16 = 1'b1; mode_hs = 1'b1;
      write_en(1'b1);
      send_frame(400, 1'b0, 4);
      write_en(1'b0);
      check("R11", "abort clears en", int'(en0), 0);
      held = int'(cnt0);
      idle(200);
      check("R11", "count frozen", int'(cnt0), held);
      check("R11", "no done on abort", int'(done0), 0);
   endtask

   task automatic t_overflow();
      mode16 = 1'b1; mode_hs = 1'b1;
      write_en(1'b1);
      send_frame(4200, 1'b0, 8);
      check("R7", "narrow count wraps", int'(cnt1), 1050 - 1024);
      check("R7", "wrap flag set", int'(ovf1), 1);
      check("R7", "measurement finished after wrap", int'(done1), 1);
      check("R3", "wide count", int'(cnt0), 1050);
      check("R7", "no wrap on wide counter", int'(ovf0), 0);
      read_data();
      @(negedge clk); ovf_wr = 1'b1; ovf_wdata = 1'b0;
      @(negedge clk); ovf_wr = 1'b0;
      check("R8", "software clear", int'(ovf1), 0);
      @(negedge clk); ovf_wr = 1'b1; ovf_wdata = 1'b1;
      @(negedge clk); ovf_wr = 1'b0; ovf_wdata = 1'b0;
      check("R8", "software set", int'(ovf0), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(3);
      t_reset();
      t_gating();
      measure(1'b1, 1'b1, 400, 100, 100, "R3");
      measure(1'b0, 1'b1, 4800, 300, 44, "R10");
      measure(1'b1, 1'b0, 320, 20, 20, "R4");
      measure(1'b0, 1'b0, 640, 10, 10, "R4");
      write_en(1'b1);
      check("R2", "re-arm clears previous count", int'(cnt0), 0);
      write_en(1'b0);
      t_abort();
      t_overflow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule